// File: doc/BRIEF.md
# IEEE-488 Addressed Listener with Acceptor Handshake

This block sits on the device side of an IEEE-488 bus. It watches the sampled bus lines and follows the controller's addressing commands. From these it decides whether the device is idle, an addressed listener or an addressed talker. While the controller holds ATN, every device has to take part in the transfer of command bytes, so the block runs the three-wire acceptor handshake for those bytes even when it is unaddressed. While ATN is released, it runs the handshake only if it is an addressed listener. In that case each accepted data byte goes downstream on a valid/ready stream, together with the end flag the talker drove on EOI.

All bus lines are active low and wired-NOR. The block therefore never drives a bus level. It only reports, on `nrfd_pull` and `ndac_pull`, whether the pad should pull NRFD or NDAC low. DAV, ATN and IFC each pass through two flip-flops. DAV must then stay asserted for `SETTLE_CYC` further cycles before the byte is taken, so that skew between the data lines and DAV does no harm. Data and EOI are sampled at the moment the byte is taken. IFC forces the addressing state back to idle and drops the handshake.

The addressing machine has three states: `AD_IDLE`, `AD_LISTEN` and `AD_TALK`. It changes state only on IFC or on a command byte. The transitions are:
- IDLE to LISTEN on a listen-own command.
- IDLE to TALK on a talk-own command.
- LISTEN to IDLE on unlisten.
- LISTEN to TALK on talk-own.
- TALK to IDLE on untalk or on a talk command to another address.
- TALK to LISTEN on listen-own.
- Any state to IDLE on IFC.

The handshake machine has four states: `HS_OFF` (both lines released), `HS_HOLD` (both pulled), `HS_READY` (NDAC pulled, NRFD released) and `HS_TAKEN` (NRFD pulled, NDAC released). Its transitions are:
- OFF to HOLD when the block has to take part.
- HOLD to READY once DAV is released and there is room for the byte.
- READY to TAKEN on a settled DAV.
- READY back to HOLD if a data byte is still pending.
- TAKEN to HOLD when DAV is released.
- Any state to OFF when the block no longer has to take part, or on IFC.

Top module: `bus488_listener`

## Requirements
- R1: After reset, `nrfd_pull`, `ndac_pull`, `out_valid`, `listen_act` and `talk_act` are all 0.
- R2: While IFC is asserted, the addressing state is forced to idle: `listen_act` and `talk_act` read 0 from the third clock edge after `ifc_n` falls, whatever the state was before.
- R3: A command byte whose true value has bits 7:5 = 001 and bits 4:0 equal to `dev_addr` (and not 31) sets `listen_act`. A listen command to any other address leaves the state unchanged.
- R4: A command byte with bits 7:5 = 001 and bits 4:0 = 31 (unlisten, true value 0x3F) returns a listener to idle.
- R5: A command byte with bits 7:5 = 010 and a matching address sets `talk_act`. While the block is talker, the untalk byte 0x5F or a talk command to a different address returns it to idle.
- R6: While taking part, the handshake cycles through these line states in order:
  - NDAC pulled and NRFD released while waiting for DAV.
  - After a settled DAV, NRFD pulled and NDAC released.
  - After DAV is released, both pulled.
  - Then NRFD released again once ready.
  - While the block stays a listener, NDAC is never released unless NRFD is pulled.
- R7: Starting from the ready state, NDAC is released at the (SETTLE_CYC+3)-th clock edge after `dav_n` falls and not earlier.
- R8: When the block is not a listener and ATN is deasserted, it releases both NRFD and NDAC. Data bytes sent in that condition produce no `out_valid`.
- R9: While ATN is asserted, the block accepts command bytes whatever its addressing state, and never delivers a command byte downstream.
- R10: An accepted data byte appears as `out_data` = ~`dio_n` with `out_eoi` = ~`eoi_n`, both sampled when the byte is taken. `out_valid` and `out_data` hold until a cycle with `out_ready` high.
- R11: While a data byte is pending (`out_valid` high, `out_ready` low) and ATN is deasserted, NRFD stays pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dio_n | input | 8 | Bus data lines, active low |
| dav_n | input | 1 | Data valid line, active low |
| eoi_n | input | 1 | End-of-transfer line, active low |
| atn_n | input | 1 | Attention line, active low |
| ifc_n | input | 1 | Interface clear line, active low |
| dev_addr | input | 5 | Device address from switches |
| nrfd_pull | output | 1 | 1 = pull NRFD low |
| ndac_pull | output | 1 | 1 = pull NDAC low |
| out_data | output | 8 | Accepted data byte, true polarity |
| out_eoi | output | 1 | EOI state that came with the byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream ready |
| listen_act | output | 1 | Addressed as listener |
| talk_act | output | 1 | Addressed as talker |

## Verification
Each bus input takes two edges to pass through its synchroniser. A settled DAV therefore moves the handshake lines at edge SETTLE_CYC+3, and ATN or IFC act on the outputs at edge three. A command byte changes `listen_act`/`talk_act` on the same edge that releases NDAC. `out_valid` clears on the first edge that sees `out_ready` high. The bench's behavioural model advances those synchroniser and settle delays edge by edge and compares every output at each falling edge. The directed checks count the exact edge for the DAV latency, and otherwise wait for the handshake to complete before looking at the addressing flags.

// File: rtl/bus488_pkg.sv
package bus488_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int GRP_W  = DATA_W - ADDR_W;

    localparam logic [GRP_W-1:0]  GRP_LISTEN = 3'b001;
    localparam logic [GRP_W-1:0]  GRP_TALK   = 3'b010;
    localparam logic [ADDR_W-1:0] ADDR_NONE  = '1;

    typedef enum logic [1:0] {AD_IDLE, AD_LISTEN, AD_TALK} addr_st_t;
    typedef enum logic [1:0] {HS_OFF, HS_HOLD, HS_READY, HS_TAKEN} hs_st_t;
endpackage

// File: rtl/bus488_sync.sv
module bus488_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_n,
    output logic [W-1:0] asserted
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= ~line_n[i];
                s2 <= s1;
            end
        end
        assign asserted[i] = s2;
    end
endmodule

// File: rtl/bus488_settle.sv
module bus488_settle #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dav_s,
    output logic dav_ok
);
    localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

    if (SETTLE_CYC == 0) begin : g_none
        assign dav_ok = dav_s;
    end else begin : g_count
        logic [CW-1:0] cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (!dav_s)
                cnt <= '0;
            else if (cnt != CW'(SETTLE_CYC))
                cnt <= cnt + 1'b1;
        end
        assign dav_ok = dav_s && (cnt == CW'(SETTLE_CYC));
    end
endmodule

// File: rtl/bus488_addr_fsm.sv
module bus488_addr_fsm
    import bus488_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifc_s,
    input  logic              cmd_stb,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              listen_act,
    output logic              talk_act
);
    addr_st_t st, nxt;

    logic [GRP_W-1:0]  grp;
    logic [ADDR_W-1:0] adr;
    logic listen_own, unlisten, talk_own, talk_drop;

    assign grp = cmd_byte[DATA_W-1:ADDR_W];
    assign adr = cmd_byte[ADDR_W-1:0];

    assign listen_own = cmd_stb && grp == GRP_LISTEN && adr == my_addr && adr != ADDR_NONE;
    assign unlisten   = cmd_stb && grp == GRP_LISTEN && adr == ADDR_NONE;
    assign talk_own   = cmd_stb && grp == GRP_TALK && adr == my_addr && adr != ADDR_NONE;
    assign talk_drop  = cmd_stb && grp == GRP_TALK && !talk_own;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= AD_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (ifc_s) begin
            nxt = AD_IDLE;
        end else begin
            unique case (st)
                AD_IDLE: begin
                    if (listen_own)    nxt = AD_LISTEN;
                    else if (talk_own) nxt = AD_TALK;
                end
                AD_LISTEN: begin
                    if (unlisten)      nxt = AD_IDLE;
                    else if (talk_own) nxt = AD_TALK;
                end
                AD_TALK: begin
                    if (talk_drop)       nxt = AD_IDLE;
                    else if (listen_own) nxt = AD_LISTEN;
                end
                default: nxt = AD_IDLE;
            endcase
        end
    end

    always_comb begin
        listen_act = (st == AD_LISTEN);
        talk_act   = (st == AD_TALK);
    end
endmodule

// File: rtl/bus488_acceptor.sv
module bus488_acceptor
    import bus488_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifc_s,
    input  logic              atn_s,
    input  logic              dav_s,
    input  logic              dav_ok,
    input  logic              listen_act,
    input  logic [DATA_W-1:0] dio_n,
    input  logic              eoi_n,
    input  logic              out_ready,
    output logic              nrfd_pull,
    output logic              ndac_pull,
    output logic              cmd_stb,
    output logic [DATA_W-1:0] cmd_byte,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eoi,
    output logic              out_valid
);
    hs_st_t st, nxt;
    logic participate, pending, take;

    assign participate = !ifc_s && (listen_act || atn_s);
    assign pending     = !atn_s && out_valid;
    assign take        = (st == HS_READY) && participate && !pending && dav_ok;
    assign cmd_stb     = take && atn_s;
    assign cmd_byte    = ~dio_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HS_OFF;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (!participate) begin
            nxt = HS_OFF;
        end else begin
            unique case (st)
                HS_OFF:   nxt = HS_HOLD;
                HS_HOLD:  if (!dav_s && !pending) nxt = HS_READY;
                HS_READY: begin
                    if (pending)     nxt = HS_HOLD;
                    else if (dav_ok) nxt = HS_TAKEN;
                end
                HS_TAKEN: if (!dav_s) nxt = HS_HOLD;
                default:  nxt = HS_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            HS_HOLD:  begin nrfd_pull = 1'b1; ndac_pull = 1'b1; end
            HS_READY: begin nrfd_pull = 1'b0; ndac_pull = 1'b1; end
            HS_TAKEN: begin nrfd_pull = 1'b1; ndac_pull = 1'b0; end
            default:  begin nrfd_pull = 1'b0; ndac_pull = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_eoi   <= 1'b0;
        end else if (take && !atn_s) begin
            out_valid <= 1'b1;
            out_data  <= ~dio_n;
            out_eoi   <= ~eoi_n;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bus488_listener.sv
module bus488_listener
    import bus488_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dio_n,
    input  logic              dav_n,
    input  logic              eoi_n,
    input  logic              atn_n,
    input  logic              ifc_n,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              nrfd_pull,
    output logic              ndac_pull,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eoi,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              listen_act,
    output logic              talk_act
);
    logic [2:0] sync_q;
    logic dav_s, atn_s, ifc_s, dav_ok, cmd_stb;
    logic [DATA_W-1:0] cmd_byte;

    bus488_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .line_n({ifc_n, atn_n, dav_n}),
        .asserted(sync_q)
    );
    assign dav_s = sync_q[0];
    assign atn_s = sync_q[1];
    assign ifc_s = sync_q[2];

    bus488_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .dav_s(dav_s), .dav_ok(dav_ok)
    );

    bus488_acceptor u_acc (
        .clk(clk), .rst_n(rst_n),
        .ifc_s(ifc_s), .atn_s(atn_s), .dav_s(dav_s), .dav_ok(dav_ok),
        .listen_act(listen_act), .dio_n(dio_n), .eoi_n(eoi_n),
        .out_ready(out_ready),
        .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull),
        .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .out_data(out_data), .out_eoi(out_eoi), .out_valid(out_valid)
    );

    bus488_addr_fsm u_addr (
        .clk(clk), .rst_n(rst_n), .ifc_s(ifc_s),
        .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .my_addr(dev_addr),
        .listen_act(listen_act), .talk_act(talk_act)
    );
endmodule

// File: rtl/bus488_listener_chk.sv
module bus488_listener_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ifc_n,
    input logic       atn_n,
    input logic       out_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       listen_act,
    input logic       talk_act,
    input logic       nrfd_pull,
    input logic       ndac_pull
);
    // R2
    ifc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ifc_n, 3) |-> (!listen_act && !talk_act));

    // R6
    ndac_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (listen_act && $past(listen_act) && $fell(ndac_pull)) |-> nrfd_pull);

    // R8
    unaddr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(atn_n, 3) && !$past(listen_act)) |-> (!nrfd_pull && !ndac_pull));

    // R9
    no_cmd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(atn_n, 3));

    // R10
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind bus488_listener bus488_listener_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ifc_n(ifc_n), .atn_n(atn_n),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .listen_act(listen_act), .talk_act(talk_act),
    .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull)
);

// File: tb/bus488_listener_test.sv
module bus488_listener_test;
    localparam int SETTLE = 2;
    localparam logic [4:0] MY = 5'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] dio_n = 8'hFF;
    logic dav_n = 1'b1, eoi_n = 1'b1, atn_n = 1'b1, ifc_n = 1'b1;
    logic out_ready = 1'b1;
    logic nrfd_pull, ndac_pull, out_eoi, out_valid, listen_act, talk_act;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus488_listener #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .dio_n(dio_n), .dav_n(dav_n), .eoi_n(eoi_n),
        .atn_n(atn_n), .ifc_n(ifc_n), .dev_addr(MY),
        .nrfd_pull(nrfd_pull), .ndac_pull(ndac_pull),
        .out_data(out_data), .out_eoi(out_eoi), .out_valid(out_valid),
        .out_ready(out_ready), .listen_act(listen_act), .talk_act(talk_act)
    );

    // Behavioural reference: role 0 idle / 1 listener / 2 talker;
    // hs 0 released / 1 both pulled / 2 waiting for DAV / 3 byte taken.
    int sd[2], sa[2], si[2];
    int m_run, m_role, m_hs;
    bit m_ov, m_oe;
    logic [7:0] m_od;

    always @(posedge clk) begin
        int dav_c, atn_c, ifc_c, hs_n, role_n;
        bit ok, part, pend, take;
        logic [7:0] b;
        if (!rst_n) begin
            sd = '{0, 0}; sa = '{0, 0}; si = '{0, 0};
            m_run = 0; m_role = 0; m_hs = 0; m_ov = 0; m_oe = 0; m_od = 0;
        end else begin
            dav_c = sd[1]; atn_c = sa[1]; ifc_c = si[1];
            ok   = (dav_c != 0) && (m_run >= SETTLE);
            part = (ifc_c == 0) && (m_role == 1 || atn_c != 0);
            pend = (atn_c == 0) && m_ov;
            take = (m_hs == 2) && part && !pend && ok;
            hs_n = m_hs;
            if (!part) hs_n = 0;
            else if (m_hs == 0) hs_n = 1;
            else if (m_hs == 1 && dav_c == 0 && !pend) hs_n = 2;
            else if (m_hs == 2 && pend) hs_n = 1;
            else if (m_hs == 2 && ok) hs_n = 3;
            else if (m_hs == 3 && dav_c == 0) hs_n = 1;
            b = ~dio_n;
            role_n = m_role;
            if (ifc_c != 0) role_n = 0;
            else if (take && atn_c != 0) begin
                if (b[7:5] == 3'd1 && b[4:0] == 5'd31) begin
                    if (m_role == 1) role_n = 0;
                end else if (b[7:5] == 3'd1 && b[4:0] == MY) role_n = 1;
                else if (b[7:5] == 3'd2 && b[4:0] == MY && MY != 5'd31) role_n = 2;
                else if (b[7:5] == 3'd2 && m_role == 2) role_n = 0;
            end
            if (take && atn_c == 0) begin
                m_ov = 1; m_od = b; m_oe = !eoi_n;
            end else if (m_ov && out_ready) m_ov = 0;
            m_hs = hs_n; m_role = role_n;
            m_run = (dav_c != 0) ? ((m_run < 1000) ? m_run + 1 : m_run) : 0;
            sd[1] = sd[0]; sd[0] = !dav_n;
            sa[1] = sa[0]; sa[0] = !atn_n;
            si[1] = si[0]; si[0] = !ifc_n;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            check("R6 nrfd model", 8'(nrfd_pull), 8'(m_hs == 1 || m_hs == 3));
            check("R6 ndac model", 8'(ndac_pull), 8'(m_hs == 1 || m_hs == 2));
            check("R3 listen model", 8'(listen_act), 8'(m_role == 1));
            check("R5 talk model", 8'(talk_act), 8'(m_role == 2));
            check("R10 valid model", 8'(out_valid), 8'(m_ov));
            if (m_ov) begin
                check("R10 data model", out_data, m_od);
                check("R10 eoi model", 8'(out_eoi), 8'(m_oe));
            end
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit e);
        while (nrfd_pull) step();
        dio_n = ~b; eoi_n = ~e;
        step();
        dav_n = 1'b0;
        step();
        while (ndac_pull) step();
        dav_n = 1'b1; dio_n = 8'hFF; eoi_n = 1'b1;
        steps(SETTLE + 6);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            failures++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        steps(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 nrfd", 8'(nrfd_pull), 8'd0);
        check("R1 ndac", 8'(ndac_pull), 8'd0);
        check("R1 valid", 8'(out_valid), 8'd0);
        check("R1 roles", {6'd0, listen_act, talk_act}, 8'd0);
        steps(4);
        // R8 unaddressed, ATN off: released
        check("R8 idle release", {6'd0, nrfd_pull, ndac_pull}, 8'd0);

        // R9 every device joins command transfers under ATN
        atn_n = 1'b0;
        steps(4);
        check("R9 ndac under atn", 8'(ndac_pull), 8'd1);
        send_byte(8'h26, 1'b0);          // listen to another address
        check("R3 other listen", 8'(listen_act), 8'd0);
        send_byte(8'h20 | 8'(MY), 1'b0); // listen own
        check("R3 listen own", 8'(listen_act), 8'd1);
        check("R9 no cmd out", 8'(out_valid), 8'd0);

        atn_n = 1'b1;
        out_ready = 1'b0;
        steps(4);
        send_byte(8'hA7, 1'b0);
        check("R10 valid", 8'(out_valid), 8'd1);
        check("R10 data", out_data, 8'hA7);
        check("R10 eoi", 8'(out_eoi), 8'd0);
        steps(6);
        check("R11 nrfd held", 8'(nrfd_pull), 8'd1);
        check("R10 still valid", 8'(out_valid), 8'd1);
        out_ready = 1'b1;
        step();
        check("R10 drained", 8'(out_valid), 8'd0);
        send_byte(8'h3C, 1'b1);
        check("R10 eoi set", 8'(out_eoi), 8'd1);
        steps(3);

        // R7 DAV latency from the ready state
        while (!(ndac_pull && !nrfd_pull)) step();
        dio_n = ~8'h55;
        step();
        dav_n = 1'b0;
        for (int k = 1; k <= SETTLE + 3; k++) begin
            step();
            if (k == SETTLE + 2) check("R7 not yet", 8'(ndac_pull), 8'd1);
            if (k == SETTLE + 3) check("R7 released", 8'(ndac_pull), 8'd0);
        end
        dav_n = 1'b1; dio_n = 8'hFF;
        steps(SETTLE + 6);
        check("R10 latency byte", out_data, 8'h55);

        // R4 unlisten
        atn_n = 1'b0;
        steps(4);
        send_byte(8'h3F, 1'b0);
        check("R4 unlisten", 8'(listen_act), 8'd0);
        atn_n = 1'b1;
        steps(5);
        check("R8 release after unlisten", {6'd0, nrfd_pull, ndac_pull}, 8'd0);
        send_byte(8'h99, 1'b0);
        check("R8 data ignored", 8'(out_valid), 8'd0);

        // R5 talk / untalk / other talker
        atn_n = 1'b0;
        steps(4);
        send_byte(8'h40 | 8'(MY), 1'b0);
        check("R5 talk own", 8'(talk_act), 8'd1);
        send_byte(8'h47, 1'b0);
        check("R5 other talker", 8'(talk_act), 8'd0);
        send_byte(8'h40 | 8'(MY), 1'b0);
        send_byte(8'h5F, 1'b0);
        check("R5 untalk", 8'(talk_act), 8'd0);

        // R2 interface clear
        send_byte(8'h20 | 8'(MY), 1'b0);
        check("R2 pre listen", 8'(listen_act), 8'd1);
        ifc_n = 1'b0;
        steps(3);
        check("R2 ifc clears", {6'd0, listen_act, talk_act}, 8'd0);
        ifc_n = 1'b1;
        atn_n = 1'b1;
        steps(6);
        check("R8 after ifc", {6'd0, nrfd_pull, ndac_pull}, 8'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule